// File: doc/BRIEF.md
# Table-Driven Register Init Sequencer

This block performs a register bring-up sequence without software. On a start pulse it first clears a control register and waits for a fixed settle time. It then reads a configuration table, one 32-bit word at a time, from a synchronous ROM port and turns the table into register writes on a simple valid/ready write bus. The table is read in-band. Its first word gives the starting target address. One reserved word moves the target address to the value in the next entry. Another reserved word ends the table. Every other word is written to the current address, and the address then steps by four.

When the table ends normally, the block reads one selected register (base plus a fixed offset). It replaces the low field of that value with a refresh-timing constant and writes the result back. The walk stops with an error in two cases: the target address falls below the configured base, or the table runs past a length limit without an end marker. A one-cycle done pulse reports the end of every run. An error flag, valid from the done pulse until the next start, tells a good run from a failed one.

Top module: `reginit_seq`

## Requirements
- R1: In the idle state a start pulse begins a run, and the first bus transfer is a write of zero to CTRL_ADDR. A start pulse during a run has no effect: the run yields one done pulse and the same writes.
- R2: After the clear write is accepted, no ROM read is issued for SETTLE_CYC cycles. The first ROM read is issued SETTLE_CYC+2 cycles after the cycle in which the clear write is accepted.
- R3: Table entry 0 is taken as the first target address and is never written as data.
- R4: An entry that is not a marker is written to the current target address, and the address then increases by 4. The writes occur in table order.
- R5: The entry value 0xAEEDDEEA is a relocation marker. It causes no write, and the entry after it becomes the new target address.
- R6: The entry value 0xAEEDEDED is an end marker. It causes no write and ends the table walk.
- R7: Before each data or marker entry is fetched, the block compares the target address with BASE_ADDR. If the address is below BASE_ADDR, the run stops: err_o is set, no further write is issued, and no read-modify-write is done.
- R8: If the table index reaches MAX_ENTRIES before an end marker, the run stops with err_o set and no read-modify-write. ROM addresses stay below MAX_ENTRIES.
- R9: After an end marker the block reads BASE_ADDR+RMW_OFFSET. It writes back the same value with bits FIELD_W-1:0 replaced by FIELD_VAL and the upper bits unchanged. This is the last write of the run.
- R10: done_o is high for exactly one cycle per run. err_o is cleared by a start that is accepted. An err_o rise occurs together with done_o.
- R11: A bus request holds its valid, address, data and direction stable until ready. No ROM read is issued while a bus request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rom_en_o | output | 1 | ROM read enable; data returns on the next cycle |
| rom_addr_o | output | IDX_W | ROM word index |
| rom_data_i | input | DW | ROM read data |
| bus_valid_o | output | 1 | Bus request valid |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | DW | Bus byte address |
| bus_wdata_o | output | DW | Bus write data |
| bus_ready_i | input | 1 | Target accepts the request this cycle |
| bus_rdata_i | input | DW | Read data, valid while a read is accepted |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Run stopped on an address or length error |

## Verification
The assertions check the per-cycle rules on every cycle. These are: request stability under backpressure, no ROM read while a bus request is pending, no write below the base, markers never written as data, ROM index within the limit, the settle gap, and the one-cycle done pulse that comes with each err rise. Other behaviours can only be shown by the bench's scenarios, because each concerns a whole run. These are: the exact order and values of the writes produced by relocation, the merged value of the read-modify-write and its absence after an abort, the length-limit stop, and a second start being ignored.

// File: rtl/reginit_pkg.sv
package reginit_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR,
    S_SETTLE,
    S_HEAD_REQ,
    S_HEAD_CAP,
    S_ENT_REQ,
    S_ENT_DEC,
    S_PUT,
    S_RELOC_REQ,
    S_RELOC_CAP,
    S_RMW_RD,
    S_RMW_WR,
    S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    ENT_DATA,
    ENT_RELOC,
    ENT_END
  } ent_kind_t;

endpackage

// File: rtl/reginit_entry_decode.sv
module reginit_entry_decode
  import reginit_pkg::*;
#(
  parameter int          DW         = 32,
  parameter logic [DW-1:0] MARK_RELOC = 32'hAEEDDEEA,
  parameter logic [DW-1:0] MARK_END   = 32'hAEEDEDED
) (
  input  logic [DW-1:0] word_i,
  output ent_kind_t     kind_o
);

  always_comb begin
    if (word_i == MARK_END) begin
      kind_o = ENT_END;
    end else if (word_i == MARK_RELOC) begin
      kind_o = ENT_RELOC;
    end else begin
      kind_o = ENT_DATA;
    end
  end

endmodule

// File: rtl/reginit_settle_timer.sv
module reginit_settle_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_n  = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_VAL); // R2

endmodule

// File: rtl/reginit_rmw_merge.sv
module reginit_rmw_merge #(
  parameter int               DW        = 32,
  parameter int               FIELD_W   = 17,
  parameter logic [FIELD_W-1:0] FIELD_VAL = 17'h00618
) (
  input  logic [DW-1:0] old_i,
  output logic [DW-1:0] merged_o
);

  generate
    if (FIELD_W >= DW) begin : g_full
      assign merged_o = FIELD_VAL[DW-1:0];
    end else begin : g_part
      assign merged_o = {old_i[DW-1:FIELD_W], FIELD_VAL};
    end
  endgenerate

endmodule

// File: rtl/reginit_seq.sv
module reginit_seq
  import reginit_pkg::*;
#(
  parameter int               DW          = 32,
  parameter int               MAX_ENTRIES = 64,
  parameter int               SETTLE_CYC  = 16,
  parameter logic [31:0]      BASE_ADDR   = 32'h4000_0100,
  parameter logic [31:0]      CTRL_ADDR   = 32'h4000_0060,
  parameter logic [31:0]      RMW_OFFSET  = 32'h0000_0084,
  parameter int               FIELD_W     = 17,
  parameter logic [FIELD_W-1:0] FIELD_VAL = 17'h00618,
  parameter logic [31:0]      MARK_RELOC  = 32'hAEEDDEEA,
  parameter logic [31:0]      MARK_END    = 32'hAEEDEDED,
  localparam int              IDX_W       = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             rom_en_o,
  output logic [IDX_W-1:0] rom_addr_o,
  input  logic [DW-1:0]    rom_data_i,
  output logic             bus_valid_o,
  output logic             bus_we_o,
  output logic [DW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic             bus_ready_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             done_o,
  output logic             err_o
);

  localparam logic [IDX_W-1:0] IDX_LIM  = IDX_W'(MAX_ENTRIES);
  localparam logic [DW-1:0]    BASE_W   = DW'(BASE_ADDR);
  localparam logic [DW-1:0]    CTRL_W   = DW'(CTRL_ADDR);
  localparam logic [DW-1:0]    RMW_ADDR = DW'(BASE_ADDR + RMW_OFFSET);
  localparam logic [DW-1:0]    STEP     = DW'(4);

  seq_state_t       state_q, state_n;
  logic [DW-1:0]    addr_q, addr_n;
  logic             addr_en;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             idx_en;
  logic [DW-1:0]    word_q;
  logic             word_en;
  logic [DW-1:0]    rd_q;
  logic             rd_en;
  logic             err_q, err_n;
  logic             err_en;
  logic             tmr_load;
  logic             tmr_expired;
  ent_kind_t        ent_kind;
  logic [DW-1:0]    merged;
  logic             below_base;
  logic             at_limit;

  reginit_entry_decode #(
    .DW        (DW),
    .MARK_RELOC(DW'(MARK_RELOC)),
    .MARK_END  (DW'(MARK_END))
  ) u_decode (
    .word_i(rom_data_i),
    .kind_o(ent_kind)
  );

  reginit_settle_timer #(
    .CYC(SETTLE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .expired_o(tmr_expired)
  );

  reginit_rmw_merge #(
    .DW       (DW),
    .FIELD_W  (FIELD_W),
    .FIELD_VAL(FIELD_VAL)
  ) u_merge (
    .old_i   (rd_q),
    .merged_o(merged)
  );

  assign below_base = (addr_q < BASE_W);
  assign at_limit   = (idx_q >= IDX_LIM);

  // next-state process
  always_comb begin
    state_n  = state_q;
    addr_n   = addr_q;
    addr_en  = 1'b0;
    idx_n    = idx_q;
    idx_en   = 1'b0;
    word_en  = 1'b0;
    rd_en    = 1'b0;
    err_n    = err_q;
    err_en   = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_n = S_CLR;
          idx_n   = '0;
          idx_en  = 1'b1;
          err_n   = 1'b0;
          err_en  = 1'b1;
        end
      end
      S_CLR: begin
        if (bus_ready_i) begin
          state_n  = S_SETTLE;
          tmr_load = 1'b1;
        end
      end
      S_SETTLE: begin
        if (tmr_expired) begin
          state_n = S_HEAD_REQ;
        end
      end
      S_HEAD_REQ: begin
        state_n = S_HEAD_CAP;
        idx_n   = idx_q + 1'b1;
        idx_en  = 1'b1;
      end
      S_HEAD_CAP: begin
        addr_n  = rom_data_i;
        addr_en = 1'b1;
        state_n = S_ENT_REQ;
      end
      S_ENT_REQ: begin
        if (below_base || at_limit) begin
          state_n = S_FIN;
          err_n   = 1'b1;
          err_en  = 1'b1;
        end else begin
          state_n = S_ENT_DEC;
          idx_n   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      S_ENT_DEC: begin
        word_en = 1'b1;
        unique case (ent_kind)
          ENT_END:   state_n = S_RMW_RD;
          ENT_RELOC: state_n = S_RELOC_REQ;
          default:   state_n = S_PUT;
        endcase
      end
      S_PUT: begin
        if (bus_ready_i) begin
          addr_n  = addr_q + STEP;
          addr_en = 1'b1;
          state_n = S_ENT_REQ;
        end
      end
      S_RELOC_REQ: begin
        if (at_limit) begin
          state_n = S_FIN;
          err_n   = 1'b1;
          err_en  = 1'b1;
        end else begin
          state_n = S_RELOC_CAP;
          idx_n   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      S_RELOC_CAP: begin
        addr_n  = rom_data_i;
        addr_en = 1'b1;
        state_n = S_ENT_REQ;
      end
      S_RMW_RD: begin
        if (bus_ready_i) begin
          rd_en   = 1'b1;
          state_n = S_RMW_WR;
        end
      end
      S_RMW_WR: begin
        if (bus_ready_i) begin
          state_n = S_FIN;
        end
      end
      S_FIN: begin
        state_n = S_IDLE;
      end
      default: begin
        state_n = S_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      idx_q   <= '0;
      word_q  <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (addr_en) addr_q <= addr_n;
      if (idx_en)  idx_q  <= idx_n;
      if (word_en) word_q <= rom_data_i;
      if (rd_en)   rd_q   <= bus_rdata_i;
      if (err_en)  err_q  <= err_n;
    end
  end

  // output decode
  always_comb begin
    bus_valid_o = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_CLR: begin
        bus_valid_o = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = CTRL_W;
      end
      S_PUT: begin
        bus_valid_o = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = addr_q;
        bus_wdata_o = word_q;
      end
      S_RMW_RD: begin
        bus_valid_o = 1'b1;
        bus_addr_o  = RMW_ADDR;
      end
      S_RMW_WR: begin
        bus_valid_o = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = RMW_ADDR;
        bus_wdata_o = merged;
      end
      default: ;
    endcase
  end

  assign rom_en_o   = (state_q == S_HEAD_REQ) ||
                      ((state_q == S_ENT_REQ) && !below_base && !at_limit) ||
                      ((state_q == S_RELOC_REQ) && !at_limit);
  assign rom_addr_o = idx_q;
  assign done_o     = (state_q == S_FIN);
  assign err_o      = err_q;

  // observation counter for the settle window
  localparam int GW = $clog2(SETTLE_CYC + 3);
  localparam logic [GW-1:0] GAP_SAT = GW'(SETTLE_CYC + 1);
  logic [GW-1:0] gap_q;
  logic          clr_acc;
  assign clr_acc = bus_valid_o && bus_ready_i && bus_we_o && (bus_addr_o == CTRL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_SAT;
    end else if (clr_acc) begin
      gap_q <= '0;
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |-> (gap_q >= GW'(SETTLE_CYC))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!bus_valid_o && !rom_en_o)); // R1
  AST_NO_MARKER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUT) |-> (bus_wdata_o != DW'(MARK_RELOC) && bus_wdata_o != DW'(MARK_END))); // R5 R6
  AST_ADDR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PUT) |-> (bus_addr_o >= BASE_W)); // R7
  AST_ROM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |-> (rom_addr_o < IDX_LIM)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o); // R10
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o))); // R11
  AST_ROM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en_o |-> !bus_valid_o); // R11

endmodule

// File: tb/reginit_seq_tb.sv
module reginit_seq_tb_top;

  localparam int          DW     = 32;
  localparam int          MAXE   = 64;
  localparam int          SETTLE = 8;
  localparam logic [31:0] BASE   = 32'h4000_0100;
  localparam logic [31:0] CTRL   = 32'h4000_0060;
  localparam int          IDX_W  = $clog2(MAXE + 1);
  localparam logic [31:0] RELOC  = 32'hAEEDDEEA;
  localparam logic [31:0] ENDW   = 32'hAEEDEDED;

  localparam int MAIN_N = 13;
  localparam logic [31:0] MAIN_ROM [0:MAIN_N-1] = '{
    32'h4000_0100, 32'h1111_1111, 32'h2222_2222, RELOC, 32'h4000_0200,
    32'h3333_3333, RELOC, 32'h4000_0120, 32'h4444_4444, 32'h5555_5555,
    RELOC, 32'h4000_0300, ENDW };
  localparam int EXP_N = 7;
  localparam logic [31:0] EXP_ADDR [0:EXP_N-1] = '{
    CTRL, 32'h4000_0100, 32'h4000_0104, 32'h4000_0200,
    32'h4000_0120, 32'h4000_0124, 32'h4000_0184 };
  localparam logic [31:0] EXP_DATA [0:EXP_N-1] = '{
    32'h0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333,
    32'h4444_4444, 32'h5555_5555, 32'hDEAC_0618 };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic             rom_en;
  logic [IDX_W-1:0] rom_addr;
  logic [DW-1:0]    rom_q;
  logic             bvalid, bwe, bready;
  logic [DW-1:0]    baddr, bwdata, brdata;
  logic             done, err;

  logic [31:0] rom_mem [0:127];
  logic [31:0] tgt [0:255];
  logic        clr_tgt;
  logic [31:0] pl_val;
  logic        rdy_mode;
  logic [7:0]  lfsr;

  logic [31:0] log_a [0:127];
  logic [31:0] log_d [0:127];
  int n_wr, n_rd, n_done, cyc, clr_cyc, rom_cyc, run_mark;
  int n_vec = 0;
  int n_mis = 0;

  always #10 clk = ~clk;

  reginit_seq #(
    .DW(DW), .MAX_ENTRIES(MAXE), .SETTLE_CYC(SETTLE),
    .BASE_ADDR(BASE), .CTRL_ADDR(CTRL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .rom_en_o(rom_en), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .bus_valid_o(bvalid), .bus_we_o(bwe), .bus_addr_o(baddr),
    .bus_wdata_o(bwdata), .bus_ready_i(bready), .bus_rdata_i(brdata),
    .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    if (rom_en) rom_q <= rom_mem[rom_addr];
  end

  assign brdata = tgt[baddr[9:2]];

  always @(posedge clk) begin
    if (clr_tgt) begin
      for (int i = 0; i < 256; i++) tgt[i] <= 32'h0;
      tgt[8'h61] <= pl_val;
    end else if (bvalid && bready && bwe) begin
      tgt[baddr[9:2]] <= bwdata;
    end
  end

  always @(posedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bready <= rdy_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bvalid && bready && bwe) begin
      log_a[n_wr[6:0]] <= baddr;
      log_d[n_wr[6:0]] <= bwdata;
      n_wr <= n_wr + 1;
      if (baddr == CTRL && clr_cyc < 0) clr_cyc <= cyc;
    end
    if (bvalid && bready && !bwe) n_rd <= n_rd + 1;
    if (rom_en && rom_cyc < 0) rom_cyc <= cyc;
    if (done) n_done <= n_done + 1;
    if (cyc > 190000) begin
      n_mis = n_mis + 1;
      $display("FAIL R10 watchdog expired act=%0d exp<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic prep(input logic rmode);
    for (int i = 0; i < 128; i++) rom_mem[i] = 32'h0;
    rdy_mode = rmode;
    @(negedge clk); #1;
    clr_tgt = 1'b1; pl_val = 32'hDEAD_BEEF;
    @(negedge clk); #1;
    clr_tgt = 1'b0;
  endtask

  task automatic run(input int extra_at);
    n_wr = 0; n_rd = 0; n_done = 0; clr_cyc = -1; rom_cyc = -1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    for (int k = 1; k < 5000 && n_done == 0; k++) begin
      @(negedge clk); #1;
      start = (k == extra_at);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
    end
    start = 1'b0;
  endtask

  task automatic main_run(input logic rmode, input int extra_at, input string tag);
    prep(rmode);
    for (int i = 0; i < MAIN_N; i++) rom_mem[i] = MAIN_ROM[i];
    run(extra_at);
    chk({tag, " R4 R5 R6 write count"}, n_wr, EXP_N);
    for (int i = 0; i < EXP_N; i++) begin
      chk({tag, " R3 R4 R5 R9 write addr"}, log_a[i], EXP_ADDR[i]);
      chk({tag, " R4 R9 write data"}, log_d[i], EXP_DATA[i]);
    end
    chk({tag, " R9 one read"}, n_rd, 1);
    chk({tag, " R9 upper bits kept"}, tgt[8'h61], 32'hDEAC_0618);
    chk({tag, " R10 done width"}, n_done, 1);
    chk({tag, " R10 err clear"}, {31'b0, err}, 0);
    chk({tag, " R2 settle gap"}, rom_cyc - clr_cyc, SETTLE + 2);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rdy_mode = 1'b0; lfsr = 8'h5A;
    clr_tgt = 1'b0; pl_val = 32'h0; cyc = 0;
    n_wr = 0; n_rd = 0; n_done = 0; clr_cyc = -1; rom_cyc = -1;
    repeat (3) @(negedge clk);
    chk("R10 reset done", {31'b0, done}, 0);
    chk("R10 reset err", {31'b0, err}, 0);
    chk("R11 reset valid", {31'b0, bvalid}, 0);
    chk("R11 reset rom_en", {31'b0, rom_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;

    main_run(1'b0, 0, "ready-high");
    main_run(1'b1, 0, "ready-stall");

    // R7: relocation below the base stops the run
    prep(1'b0);
    rom_mem[0] = 32'h4000_0100; rom_mem[1] = 32'h0000_AAAA;
    rom_mem[2] = RELOC;         rom_mem[3] = 32'h4000_00F0;
    rom_mem[4] = 32'h0000_BBBB; rom_mem[5] = ENDW;
    run(0);
    chk("R7 err set", {31'b0, err}, 1);
    chk("R7 writes", n_wr, 2);
    chk("R7 last write", log_d[1], 32'h0000_AAAA);
    chk("R7 no rmw read", n_rd, 0);
    chk("R7 below-base word untouched", tgt[8'h3C], 32'h0);
    chk("R7 rmw reg untouched", tgt[8'h61], 32'hDEAD_BEEF);
    chk("R10 done width abort", n_done, 1);

    // R7: first address already below the base
    prep(1'b0);
    rom_mem[0] = 32'h4000_0000; rom_mem[1] = 32'h1234_5678; rom_mem[2] = ENDW;
    run(0);
    chk("R7 head below base err", {31'b0, err}, 1);
    chk("R7 head below base writes", n_wr, 1);

    // R10: err cleared by the next accepted start
    main_run(1'b0, 0, "after-abort");

    // R8: table without end marker
    prep(1'b1);
    rom_mem[0] = 32'h4000_0100;
    for (int i = 1; i < 128; i++) rom_mem[i] = 32'h0001_0000 + i;
    run(0);
    chk("R8 err set", {31'b0, err}, 1);
    chk("R8 writes", n_wr, MAXE);
    chk("R8 last data", log_d[MAXE-1], 32'h0001_0000 + MAXE - 1);
    chk("R8 no rmw read", n_rd, 0);

    // R1: start during a run is ignored
    main_run(1'b0, 6, "restart-ignored R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end

endmodule